// File: doc/BRIEF.md
# FIFO Threshold-Crossing Interrupt Generator

This block sits beside the receive and transmit FIFOs of a serial port and asks for service when either FIFO's fill level passes a software-chosen fraction of its depth. It receives each FIFO's current fill count together with one-cycle push and pop strobes. From these it works out whether the strobe in that cycle carries the count across the selected threshold. Receive asks for service when the level climbs through the threshold. Transmit asks for service when the level drains through it. A FIFO that merely stays on one side of the threshold never raises a request.

Software picks the thresholds through a 32-bit register that holds two 3-bit level codes. Each direction has a sticky interrupt flag, and software clears it by writing one to a dedicated clear input. The FIFO storage, the interrupt masking and the serial logic all sit outside this block.

Top module: `fifo_level_irq`

## Requirements
- R1: After reset the register reads 0x00000012, so both level codes are 3'b010, and rx_irq and tx_irq are 0.
- R2: A cycle with reg_wr_en high stores reg_wr_data[5:0]. From the next cycle, reg_rd_data shows those bits in [5:0] with bits [31:6] at zero. Reserved codes read back exactly as written.
- R3: The receive code is reg_rd_data[5:3]. For a 16-entry FIFO, codes 0,1,2,3,4 give the thresholds 2,4,8,12,14 entries, which are 1/8, 1/4, 1/2, 3/4 and 7/8 of the depth.
- R4: rx_irq becomes 1 in the cycle after rx_push is high without rx_pop while rx_count is below the receive threshold and rx_count+1 reaches it. A push while the count is already at or above the threshold, or still short of it, raises nothing.
- R5: The transmit code is reg_rd_data[2:0] and uses the same threshold table as R3. tx_irq becomes 1 in the cycle after tx_pop is high without tx_push while tx_count is above the threshold and tx_count-1 is at or below it.
- R6: A cycle with both the push and the pop strobe of a FIFO high leaves its level unchanged and raises no crossing.
- R7: Codes 5, 6 and 7 disable crossing detection for that direction.
- R8: A flag stays set until it is cleared. irq_clr[0] clears rx_irq and irq_clr[1] clears tx_irq, and the flag reads 0 in the following cycle.
- R9: When a crossing and a clear of the same flag occur in the same cycle, the flag stays set.
- R10: A write to the register never raises a flag by itself. A crossing in the same cycle as a write is judged against the code in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the level-select register |
| reg_wr_data | input | 32 | Write data. Only bits 5:0 are kept |
| reg_rd_data | output | 32 | Register contents. Bits 31:6 are zero |
| rx_count | input | 5 | Receive FIFO fill count before this cycle's strobes |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| tx_count | input | 5 | Transmit FIFO fill count before this cycle's strobes |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 receive, bit 1 transmit |
| rx_irq | output | 1 | Sticky receive service request |
| tx_irq | output | 1 | Sticky transmit service request |

## Verification
The assertions check on every cycle that a flag holds until it is cleared and that a same-cycle crossing beats the clear. They also check that register writes read back next cycle with the upper bits at zero, that a receive flag rises only after a lone push and a transmit flag only after a lone pop, and that no flag rises while its code is reserved. The exact threshold each code selects, the absence of retriggering while a level stays beyond the threshold, and the rule that a write in the same cycle as a crossing is judged against the old code can only be shown by the bench. Its scenarios sweep every code in both directions, with strobes placed just on and just off each threshold.

// File: rtl/fli_pkg.sv
package fli_pkg;

    localparam int unsigned SEL_W   = 3;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned FIELD_W = 2 * SEL_W;

    // Fields of the level-select register; rx occupies [5:3], tx [2:0].
    typedef struct packed {
        logic [SEL_W-1:0] rx;
        logic [SEL_W-1:0] tx;
    } sel_t;

    localparam sel_t SEL_RESET = '{rx: 3'b010, tx: 3'b010};

    // Threshold expressed in eighths of the FIFO depth; 0 marks a reserved code.
    function automatic int unsigned level_eighths(input logic [SEL_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 7;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fli_sel_reg.sv
module fli_sel_reg
    import fli_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_bits,
    output sel_t               sel
);

    typedef struct packed {
        sel_t sel;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.sel = sel_t'(wr_bits);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel <= SEL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = st_q.sel;

endmodule

// File: rtl/fli_thr_decode.sv
module fli_thr_decode
    import fli_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic [SEL_W-1:0] code,
    output logic [CW-1:0]    thr,
    output logic             en
);

    int unsigned eighths;

    always_comb begin
        eighths = level_eighths(code);
        en      = (eighths != 0);
        thr     = CW'((DEPTH * eighths) / 8);
    end

endmodule

// File: rtl/fli_cross_det.sv
module fli_cross_det #(
    parameter int unsigned CW     = 5,
    parameter bit          RISING = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          push,
    input  logic          pop,
    input  logic [CW-1:0] thr,
    input  logic          en,
    input  logic          clr,
    output logic          flag
);

    typedef struct packed {
        logic flag;
    } state_t;

    state_t st_d, st_q;
    logic   hit;

    generate
        if (RISING) begin : g_fill
            logic [CW:0] up_cnt;
            always_comb begin
                up_cnt = {1'b0, cnt} + 1'b1;
                hit    = en && push && !pop && (cnt < thr) && (up_cnt >= {1'b0, thr});
            end
        end else begin : g_drain
            logic [CW-1:0] dn_cnt;
            always_comb begin
                dn_cnt = cnt - 1'b1;
                hit    = en && pop && !push && (cnt > thr) && (dn_cnt <= thr);
            end
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.flag = 1'b0;
        end
        if (hit) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R8: a set flag with no clear request stays set
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R8: a clear without a crossing empties the flag
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);

    // R9: a crossing beats a simultaneous clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr) |=> flag);

endmodule

// File: rtl/fifo_level_irq.sv
module fifo_level_irq
    import fli_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic [CW-1:0]    rx_count,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic [CW-1:0]    tx_count,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic [1:0]       irq_clr,
    output logic             rx_irq,
    output logic             tx_irq
);

    sel_t          sel;
    logic [CW-1:0] rx_thr, tx_thr;
    logic          rx_en, tx_en;
    logic          unused_wr_hi;

    assign unused_wr_hi = ^reg_wr_data[REG_W-1:FIELD_W];

    fli_sel_reg u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_bits (reg_wr_data[FIELD_W-1:0]),
        .sel     (sel)
    );

    assign reg_rd_data = {{(REG_W-FIELD_W){1'b0}}, sel};

    fli_thr_decode #(.DEPTH(DEPTH), .CW(CW)) u_rx_dec (
        .code (sel.rx),
        .thr  (rx_thr),
        .en   (rx_en)
    );

    fli_thr_decode #(.DEPTH(DEPTH), .CW(CW)) u_tx_dec (
        .code (sel.tx),
        .thr  (tx_thr),
        .en   (tx_en)
    );

    fli_cross_det #(.CW(CW), .RISING(1'b1)) u_rx_det (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (rx_count),
        .push  (rx_push),
        .pop   (rx_pop),
        .thr   (rx_thr),
        .en    (rx_en),
        .clr   (irq_clr[0]),
        .flag  (rx_irq)
    );

    fli_cross_det #(.CW(CW), .RISING(1'b0)) u_tx_det (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (tx_count),
        .push  (tx_push),
        .pop   (tx_pop),
        .thr   (tx_thr),
        .en    (tx_en),
        .clr   (irq_clr[1]),
        .flag  (tx_irq)
    );

    // R2: written low bits read back next cycle, reserved bits zero
    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rd_data == {{(REG_W-FIELD_W){1'b0}}, $past(reg_wr_data[FIELD_W-1:0])}));

    // R4: a receive request rises only after a lone push
    p_rx_push_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(rx_push && !rx_pop));

    // R5: a transmit request rises only after a lone pop
    p_tx_pop_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) |-> $past(tx_pop && !tx_push));

    // R7: no receive request under a reserved code
    p_rx_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> ($past(reg_rd_data[5:3]) <= 3'd4));

    // R7: no transmit request under a reserved code
    p_tx_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) |-> ($past(reg_rd_data[2:0]) <= 3'd4));

endmodule

// File: tb/sim_fifo_level_irq.sv
module sim_fifo_level_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic [4:0]  rx_count = '0;
    logic        rx_push = 1'b0;
    logic        rx_pop = 1'b0;
    logic [4:0]  tx_count = '0;
    logic        tx_push = 1'b0;
    logic        tx_pop = 1'b0;
    logic [1:0]  irq_clr = '0;
    logic        rx_irq, tx_irq;

    always #4 clk = ~clk;

    fifo_level_irq u0 (
        .clk (clk), .rst_n (rst_n),
        .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data), .reg_rd_data (reg_rd_data),
        .rx_count (rx_count), .rx_push (rx_push), .rx_pop (rx_pop),
        .tx_count (tx_count), .tx_push (tx_push), .tx_pop (tx_pop),
        .irq_clr (irq_clr), .rx_irq (rx_irq), .tx_irq (tx_irq)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic        q_rx[$];
    logic        q_tx[$];
    logic [31:0] q_rd[$];
    string       q_tag[$];

    logic [5:0] m_sel = 6'h12;
    logic       m_rx = 1'b0;
    logic       m_tx = 1'b0;

    function automatic int thr_of(input logic [2:0] code);
        case (code)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 12;
            3'd4: return 14;
            default: return -1;
        endcase
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected outcome.
    task automatic step(input string tag, input bit we, input logic [31:0] wd,
                        input int rc, input bit rpu, input bit rpo,
                        input int tc, input bit tpu, input bit tpo,
                        input logic [1:0] clr);
        int  rt, tt;
        bit  rx_hit, tx_hit;
        @(negedge clk);
        reg_wr_en = we; reg_wr_data = wd;
        rx_count = 5'(rc); rx_push = rpu; rx_pop = rpo;
        tx_count = 5'(tc); tx_push = tpu; tx_pop = tpo;
        irq_clr = clr;
        rt = thr_of(m_sel[5:3]);
        tt = thr_of(m_sel[2:0]);
        rx_hit = (rt >= 0) && rpu && !rpo && (rc < rt) && (rc + 1 >= rt);
        tx_hit = (tt >= 0) && tpo && !tpu && (tc > tt) && (tc - 1 <= tt);
        m_rx = rx_hit || (m_rx && !clr[0]);
        m_tx = tx_hit || (m_tx && !clr[1]);
        if (we) m_sel = wd[5:0];
        q_rx.push_back(m_rx);
        q_tx.push_back(m_tx);
        q_rd.push_back({26'd0, m_sel});
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 16, 0, 0, 2'b00);
    endtask

    task automatic wr(input string tag, input logic [31:0] d);
        step(tag, 1, d, 0, 0, 0, 16, 0, 0, 2'b00);
    endtask

    task automatic clr_all(input string tag);
        step(tag, 0, 0, 0, 0, 0, 16, 0, 0, 2'b11);
    endtask

    // Monitor: compares each registered result in the middle of the high phase.
    always @(posedge clk) begin
        #2;
        if (rst_n && q_tag.size() > 0) begin
            logic        e_rx, e_tx;
            logic [31:0] e_rd;
            string       t;
            e_rx = q_rx.pop_front();
            e_tx = q_tx.pop_front();
            e_rd = q_rd.pop_front();
            t    = q_tag.pop_front();
            total++;
            if (rx_irq !== e_rx || tx_irq !== e_tx || reg_rd_data !== e_rd) begin
                bad++;
                $display("FAIL %s: rx_irq=%0b tx_irq=%0b rd=%h expected rx_irq=%0b tx_irq=%0b rd=%h",
                         t, rx_irq, tx_irq, reg_rd_data, e_rx, e_tx, e_rd);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset value of register and flags
        idle("R1 reset state");

        // R4: default receive threshold 8
        step("R4 rx 7->8 sets", 0, 0, 7, 1, 0, 16, 0, 0, 2'b00);
        step("R4 rx above holds", 0, 0, 8, 1, 0, 16, 0, 0, 2'b00);
        step("R8 rx clear", 0, 0, 0, 0, 0, 16, 0, 0, 2'b01);
        step("R4 rx 9->10 no retrigger", 0, 0, 9, 1, 0, 16, 0, 0, 2'b00);
        step("R4 rx 5->6 below", 0, 0, 5, 1, 0, 16, 0, 0, 2'b00);
        step("R6 rx push+pop at 7", 0, 0, 7, 1, 1, 16, 0, 0, 2'b00);

        // R5: default transmit threshold 8
        step("R5 tx 9->8 sets", 0, 0, 0, 0, 0, 9, 0, 1, 2'b00);
        step("R8 tx clear", 0, 0, 0, 0, 0, 16, 0, 0, 2'b10);
        step("R5 tx 8->7 no retrigger", 0, 0, 0, 0, 0, 8, 0, 1, 2'b00);
        step("R6 tx push+pop at 9", 0, 0, 0, 0, 0, 9, 1, 1, 2'b00);

        // R3 / R5: sweep every valid code in both directions
        for (int c = 0; c < 5; c++) begin
            int t;
            t = thr_of(3'(c));
            wr("R2 write code", {26'd0, 3'(c), 3'(c)});
            step("R3 rx just short", 0, 0, t - 2, 1, 0, 16, 0, 0, 2'b00);
            step("R3 rx crossing", 0, 0, t - 1, 1, 0, 16, 0, 0, 2'b00);
            step("R5 tx just short", 0, 0, 0, 0, 0, t + 2, 0, 1, 2'b00);
            step("R5 tx crossing", 0, 0, 0, 0, 0, t + 1, 0, 1, 2'b00);
            clr_all("R8 clear both");
        end

        // R7: reserved codes disable detection and read back as written
        wr("R2 upper bits dropped", 32'hFFFF_FFFF);
        for (int k = 0; k < 16; k++) begin
            step("R7 reserved no rx or tx", 0, 0, k, 1, 0, k + 1, 0, 1, 2'b00);
        end
        wr("R2 reserved readback", 32'h0000_002D);
        step("R7 reserved 5 rx at 13", 0, 0, 13, 1, 0, 16, 0, 0, 2'b00);

        // R9: set beats a same-cycle clear
        wr("R2 restore", 32'h12);
        step("R9 rx set", 0, 0, 7, 1, 0, 16, 0, 0, 2'b00);
        step("R9 rx set and clear", 0, 0, 7, 1, 0, 9, 0, 1, 2'b11);
        clr_all("R8 clear after R9");

        // R10: a write judged against the old code, and raises nothing itself
        step("R10 write with push 3->4", 1, 32'h0A, 3, 1, 0, 16, 0, 0, 2'b00);
        idle("R10 no flag after code change");
        step("R10 write with push 7->8", 1, 32'h12, 7, 1, 0, 16, 0, 0, 2'b00);
        step("R10 new code in force", 0, 0, 7, 1, 0, 16, 0, 0, 2'b00);
        clr_all("R8 final clear");

        wait (q_tag.size() == 0);
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule